// File: doc/BRIEF.md
# Entropy Seed Management Controller

This block sequences reseeding for a random bit generator built around a block cipher. Before every seed it waits for one new sound sample and one new three-axis acceleration sample from two sensor receivers. It bundles them with a snapshot of a chaotic-map value and hands the bundle to an external mixing-hash engine. The digest that comes back is the seed, and it goes to an external cipher engine. Raw sensor values never reach the cipher.

If the sensors do not both deliver within a programmable number of cycles, the controller seeds the cipher from the chaotic-map value instead, so generation never stalls. It also raises a sticky flag to record that this happened. After each seed the cipher runs for a programmable number of output words. Each word goes to a storage sink when recording is enabled and is dropped when it is not. The controller then returns to collecting entropy.

Every exchange with the sensors, the hash engine, the cipher and the sink uses a valid/ready handshake. A payload moves only in a cycle where both signals are high.

Top module: `seed_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the cycle after `soft_rst_i` is sampled high, the following outputs are all low: `snd_ready_o`, `acc_ready_o`, `hreq_valid_o`, `hrsp_ready_o`, `seed_valid_o`, `blk_ready_o`, `sto_valid_o` and `timeout_o`.
- R2: While idle, the controller stays idle until `start_i` is high. Until then no sensor sample is accepted, no hash request is made and no seed is offered, whatever the sensor valids do.
- R3: While collecting, each sensor port is ready only while it holds no unused sample. An accepted sample drops that port's ready in the next cycle. A hash request is made only once both samples are held.
- R4: The hash request payload is {sound[SND_W-1:0], accel[ACC_W-1:0], chaos[SEED_W-1:0]}, with sound in the most significant bits. The chaos value is captured in the cycle both samples are held. `hreq_valid_o` and the payload stay unchanged until `hreq_ready_i` is high.
- R5: A mixed seed is offered only after a hash response has been accepted. Its data equal the response data, and `seed_fb_o` is 0. `seed_valid_o`, `seed_data_o` and `seed_fb_o` stay unchanged until `seed_ready_i` is high.
- R6: Suppose `tmo_cfg_i`+1 cycles pass in the collect state without both samples. The controller then offers `chaos_i` from that cycle as the seed, with `seed_fb_o` = 1, and makes no hash request. It also sets `timeout_o`, which stays high until `soft_rst_i` or `rst_n`.
- R7: Samples consumed by a hash request are discarded, so the next seed needs a new sample from both sensors. A sample that is held when a timeout occurs is kept and used for the next seed.
- R8: After a seed is accepted, the controller takes exactly `blk_cfg_i` words from the cipher, with a value of 0 treated as 1. It then lowers `blk_ready_o` and returns to collecting.
- R9: With `rec_en_i` high, each cipher word is passed to the sink unchanged, and a word is taken from the cipher only when the sink is ready. With `rec_en_i` low, words are still taken from the cipher but `sto_valid_o` stays low.
- R10: `soft_rst_i` discards a partially collected sample. After a restart both sensor ports are ready again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous active-high return to idle; clears held samples and the timeout flag |
| start_i | input | 1 | Allows leaving idle |
| rec_en_i | input | 1 | Forward cipher words to the sink |
| tmo_cfg_i | input | TMO_W | Collect timeout in cycles (minus one) |
| blk_cfg_i | input | BLK_W | Cipher words per seed (0 means 1) |
| chaos_i | input | SEED_W | Chaotic-map value |
| snd_valid_i | input | 1 | Sound sample valid |
| snd_data_i | input | SND_W | Sound sample |
| snd_ready_o | output | 1 | Sound sample ready |
| acc_valid_i | input | 1 | Acceleration sample valid |
| acc_data_i | input | AXIS_W*AXES | Packed three-axis acceleration sample |
| acc_ready_o | output | 1 | Acceleration sample ready |
| hreq_valid_o | output | 1 | Hash request valid |
| hreq_ready_i | input | 1 | Hash request ready |
| hreq_data_o | output | SND_W+AXIS_W*AXES+SEED_W | Hash request payload |
| hrsp_valid_i | input | 1 | Hash digest valid |
| hrsp_data_i | input | SEED_W | Hash digest |
| hrsp_ready_o | output | 1 | Hash digest ready |
| seed_valid_o | output | 1 | Seed valid toward the cipher |
| seed_ready_i | input | 1 | Cipher seed ready |
| seed_data_o | output | SEED_W | Seed value |
| seed_fb_o | output | 1 | Seed came from the chaotic-map fallback |
| blk_valid_i | input | 1 | Cipher word valid |
| blk_data_i | input | WORD_W | Cipher word |
| blk_ready_o | output | 1 | Cipher word ready |
| sto_valid_o | output | 1 | Sink word valid |
| sto_ready_i | input | 1 | Sink ready |
| sto_data_o | output | WORD_W | Sink word |
| timeout_o | output | 1 | Sticky fallback flag |

## Verification
The properties assume that every upstream party keeps its valid and payload steady until the transfer completes. They also assume that `soft_rst_i` is not pulsed in the middle of a hash or seed exchange. The stimulus follows both rules: the sensor driver tasks hold valid until they see ready, and the hash and cipher models change data only after a completed transfer. `chaos_i` and the configuration inputs change only while the controller is collecting or generating. The hash, seed and sink ready lines are driven from a repeating pattern, so back-pressure is exercised on all three.

// File: rtl/seed_ctrl_pkg.sv
`timescale 1ns/1ps
package seed_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_HREQ = 3'd2,
    ST_HRSP = 3'd3,
    ST_SEED = 3'd4,
    ST_GEN  = 3'd5
  } seed_st_e;
endpackage

// File: rtl/seed_cnt.sv
`timescale 1ns/1ps
module seed_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (inc) q <= q + ONE;
  end
endmodule

// File: rtl/seed_slot.sv
`timescale 1ns/1ps
module seed_slot #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush_i,
  input  logic         take_i,
  input  logic         open_i,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_data_i,
  output logic         in_ready_o,
  output logic         fresh_o,
  output logic [W-1:0] data_o
);
  logic         fresh_q;
  logic [W-1:0] data_q;
  logic         accept;

  assign in_ready_o = open_i && !fresh_q;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fresh_q <= 1'b0;
    else if (flush_i)   fresh_q <= 1'b0;
    else if (accept)    fresh_q <= 1'b1;
    else if (take_i)    fresh_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (accept) data_q <= in_data_i;
  end

  assign fresh_o = fresh_q;
  assign data_o  = data_q;
endmodule

// File: rtl/seed_fsm.sv
`timescale 1ns/1ps
module seed_fsm
  import seed_ctrl_pkg::*;
#(
  parameter int TMO_W = 16,
  parameter int BLK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             start_i,
  input  logic             both_fresh_i,
  input  logic [TMO_W-1:0] tmo_cfg_i,
  input  logic [BLK_W-1:0] blk_cfg_i,
  input  logic             hreq_ready_i,
  input  logic             hrsp_valid_i,
  input  logic             seed_ready_i,
  input  logic             blk_xfer_i,
  output seed_st_e         state_o,
  output logic             go_hash_o,
  output logic             go_fb_o,
  output logic             rsp_take_o
);
  seed_st_e         st_q, st_d;
  logic [TMO_W-1:0] wait_cnt;
  logic [BLK_W-1:0] blk_cnt;
  logic [BLK_W:0]   blk_cnt_p1;
  logic             blk_last;
  logic             in_wait, in_gen;

  assign in_wait = (st_q == ST_WAIT);
  assign in_gen  = (st_q == ST_GEN);

  seed_cnt #(.W(TMO_W)) u_wait_cnt (
    .clk (clk), .rst_n (rst_n),
    .clr (!in_wait || flush_i), .inc (in_wait),
    .q   (wait_cnt)
  );

  seed_cnt #(.W(BLK_W)) u_blk_cnt (
    .clk (clk), .rst_n (rst_n),
    .clr (!in_gen || flush_i), .inc (in_gen && blk_xfer_i),
    .q   (blk_cnt)
  );

  assign blk_cnt_p1 = {1'b0, blk_cnt} + {{BLK_W{1'b0}}, 1'b1};
  assign blk_last   = (blk_cnt_p1 >= {1'b0, blk_cfg_i});

  assign go_hash_o  = !flush_i && in_wait && both_fresh_i;
  assign go_fb_o    = !flush_i && in_wait && !both_fresh_i && (wait_cnt >= tmo_cfg_i);
  assign rsp_take_o = !flush_i && (st_q == ST_HRSP) && hrsp_valid_i;

  always_comb begin
    st_d = st_q;
    if (flush_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) st_d = ST_WAIT;
        ST_WAIT: begin
          if (go_hash_o)    st_d = ST_HREQ;
          else if (go_fb_o) st_d = ST_SEED;
        end
        ST_HREQ: if (hreq_ready_i) st_d = ST_HRSP;
        ST_HRSP: if (hrsp_valid_i) st_d = ST_SEED;
        ST_SEED: if (seed_ready_i) st_d = ST_GEN;
        ST_GEN:  if (blk_xfer_i && blk_last) st_d = ST_WAIT;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/seed_rec_gate.sv
`timescale 1ns/1ps
module seed_rec_gate #(
  parameter int WORD_W = 32
) (
  input  logic              gen_i,
  input  logic              rec_en_i,
  input  logic              blk_valid_i,
  input  logic [WORD_W-1:0] blk_data_i,
  output logic              blk_ready_o,
  output logic              sto_valid_o,
  input  logic              sto_ready_i,
  output logic [WORD_W-1:0] sto_data_o,
  output logic              blk_xfer_o
);
  assign blk_ready_o = gen_i && (!rec_en_i || sto_ready_i);
  assign sto_valid_o = gen_i && rec_en_i && blk_valid_i;
  assign sto_data_o  = blk_data_i;
  assign blk_xfer_o  = blk_valid_i && blk_ready_o;
endmodule

// File: rtl/seed_ctrl.sv
`timescale 1ns/1ps
module seed_ctrl
  import seed_ctrl_pkg::*;
#(
  parameter int SND_W  = 12,
  parameter int AXIS_W = 12,
  parameter int AXES   = 3,
  parameter int SEED_W = 32,
  parameter int WORD_W = 32,
  parameter int TMO_W  = 16,
  parameter int BLK_W  = 8,
  localparam int ACC_W = AXIS_W * AXES,
  localparam int MSG_W = SND_W + ACC_W + SEED_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst_i,
  input  logic              start_i,
  input  logic              rec_en_i,
  input  logic [TMO_W-1:0]  tmo_cfg_i,
  input  logic [BLK_W-1:0]  blk_cfg_i,
  input  logic [SEED_W-1:0] chaos_i,
  input  logic              snd_valid_i,
  input  logic [SND_W-1:0]  snd_data_i,
  output logic              snd_ready_o,
  input  logic              acc_valid_i,
  input  logic [ACC_W-1:0]  acc_data_i,
  output logic              acc_ready_o,
  output logic              hreq_valid_o,
  input  logic              hreq_ready_i,
  output logic [MSG_W-1:0]  hreq_data_o,
  input  logic              hrsp_valid_i,
  input  logic [SEED_W-1:0] hrsp_data_i,
  output logic              hrsp_ready_o,
  output logic              seed_valid_o,
  input  logic              seed_ready_i,
  output logic [SEED_W-1:0] seed_data_o,
  output logic              seed_fb_o,
  input  logic              blk_valid_i,
  input  logic [WORD_W-1:0] blk_data_i,
  output logic              blk_ready_o,
  output logic              sto_valid_o,
  input  logic              sto_ready_i,
  output logic [WORD_W-1:0] sto_data_o,
  output logic              timeout_o
);
  seed_st_e          state;
  logic              go_hash, go_fb, rsp_take, blk_xfer;
  logic              snd_fresh, acc_fresh, in_wait;
  logic [SND_W-1:0]  snd_q;
  logic [ACC_W-1:0]  acc_q;
  logic [MSG_W-1:0]  msg_q;
  logic [SEED_W-1:0] seed_q;
  logic              fb_q, tmo_q;

  assign in_wait = (state == ST_WAIT) && !soft_rst_i;

  seed_slot #(.W(SND_W)) u_snd_slot (
    .clk (clk), .rst_n (rst_n), .flush_i (soft_rst_i), .take_i (go_hash),
    .open_i (in_wait), .in_valid_i (snd_valid_i), .in_data_i (snd_data_i),
    .in_ready_o (snd_ready_o), .fresh_o (snd_fresh), .data_o (snd_q)
  );

  seed_slot #(.W(ACC_W)) u_acc_slot (
    .clk (clk), .rst_n (rst_n), .flush_i (soft_rst_i), .take_i (go_hash),
    .open_i (in_wait), .in_valid_i (acc_valid_i), .in_data_i (acc_data_i),
    .in_ready_o (acc_ready_o), .fresh_o (acc_fresh), .data_o (acc_q)
  );

  seed_fsm #(.TMO_W(TMO_W), .BLK_W(BLK_W)) u_fsm (
    .clk (clk), .rst_n (rst_n), .flush_i (soft_rst_i), .start_i (start_i),
    .both_fresh_i (snd_fresh && acc_fresh),
    .tmo_cfg_i (tmo_cfg_i), .blk_cfg_i (blk_cfg_i),
    .hreq_ready_i (hreq_ready_i), .hrsp_valid_i (hrsp_valid_i),
    .seed_ready_i (seed_ready_i), .blk_xfer_i (blk_xfer),
    .state_o (state), .go_hash_o (go_hash), .go_fb_o (go_fb),
    .rsp_take_o (rsp_take)
  );

  seed_rec_gate #(.WORD_W(WORD_W)) u_gate (
    .gen_i (state == ST_GEN), .rec_en_i (rec_en_i),
    .blk_valid_i (blk_valid_i), .blk_data_i (blk_data_i),
    .blk_ready_o (blk_ready_o), .sto_valid_o (sto_valid_o),
    .sto_ready_i (sto_ready_i), .sto_data_o (sto_data_o),
    .blk_xfer_o (blk_xfer)
  );

  // message snapshot: sensors plus chaos value at the moment both are held
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       msg_q <= '0;
    else if (go_hash) msg_q <= {snd_q, acc_q, chaos_i};
  end

  // seed register: digest from the hash, or the chaos value on timeout
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed_q <= '0;
      fb_q   <= 1'b0;
    end else if (rsp_take) begin
      seed_q <= hrsp_data_i;
      fb_q   <= 1'b0;
    end else if (go_fb) begin
      seed_q <= chaos_i;
      fb_q   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tmo_q <= 1'b0;
    else if (soft_rst_i) tmo_q <= 1'b0;
    else if (go_fb)      tmo_q <= 1'b1;
  end

  assign hreq_valid_o = (state == ST_HREQ);
  assign hreq_data_o  = msg_q;
  assign hrsp_ready_o = (state == ST_HRSP);
  assign seed_valid_o = (state == ST_SEED);
  assign seed_data_o  = seed_q;
  assign seed_fb_o    = fb_q;
  assign timeout_o    = tmo_q;
endmodule

// File: rtl/seed_ctrl_chk.sv
`timescale 1ns/1ps
module seed_ctrl_chk #(
  parameter int MSG_W  = 80,
  parameter int SEED_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst_i,
  input logic              rec_en_i,
  input logic              snd_valid_i,
  input logic              snd_ready_o,
  input logic              acc_valid_i,
  input logic              acc_ready_o,
  input logic              hreq_valid_o,
  input logic              hreq_ready_i,
  input logic [MSG_W-1:0]  hreq_data_o,
  input logic              hrsp_ready_o,
  input logic              seed_valid_o,
  input logic              seed_ready_i,
  input logic [SEED_W-1:0] seed_data_o,
  input logic              seed_fb_o,
  input logic              blk_ready_o,
  input logic              sto_valid_o,
  input logic              timeout_o
);
  // R1
  soft_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_i |=> !snd_ready_o && !acc_ready_o && !hreq_valid_o && !hrsp_ready_o
                   && !seed_valid_o && !blk_ready_o && !sto_valid_o && !timeout_o);

  // R3
  snd_one_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snd_valid_i && snd_ready_o |=> !snd_ready_o);

  // R3
  acc_one_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid_i && acc_ready_o |=> !acc_ready_o);

  // R4
  hreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hreq_valid_o && !hreq_ready_i && !soft_rst_i |=> hreq_valid_o && $stable(hreq_data_o));

  // R5
  seed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_valid_o && !seed_ready_i && !soft_rst_i
      |=> seed_valid_o && $stable(seed_data_o) && $stable(seed_fb_o));

  // R6
  timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o && !soft_rst_i |=> timeout_o);

  // R9
  rec_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_en_i |-> !sto_valid_o);
endmodule

bind seed_ctrl seed_ctrl_chk #(.MSG_W(MSG_W), .SEED_W(SEED_W)) u_chk (.*);

// File: tb/sim_seed_ctrl.sv
`timescale 1ns/1ps
module sim_seed_ctrl;
  logic        clk;
  logic        rst_n, soft_rst_i, start_i, rec_en_i;
  logic [15:0] tmo_cfg_i;
  logic [7:0]  blk_cfg_i;
  logic [31:0] chaos_i;
  logic        snd_valid_i, snd_ready_o;
  logic [11:0] snd_data_i;
  logic        acc_valid_i, acc_ready_o;
  logic [35:0] acc_data_i;
  logic        hreq_valid_o, hreq_ready_i;
  logic [79:0] hreq_data_o;
  logic        hrsp_valid_i, hrsp_ready_o;
  logic [31:0] hrsp_data_i;
  logic        seed_valid_o, seed_ready_i, seed_fb_o;
  logic [31:0] seed_data_o;
  logic        blk_valid_i, blk_ready_o;
  logic [31:0] blk_data_i;
  logic        sto_valid_o, sto_ready_i;
  logic [31:0] sto_data_o;
  logic        timeout_o;

  int vectors = 0;
  int fails   = 0;
  int seeds_seen = 0;
  int blk_since  = 0;
  int sto_cnt    = 0;
  int cyc        = 0;
  bit blk_step   = 0;
  logic [79:0] msgq[$];
  logic [32:0] seedq[$];
  logic [31:0] stq[$];

  seed_ctrl u0 (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] hfn(input logic [79:0] m);
    return m[31:0] ^ m[63:32] ^ {16'h0, m[79:64]} ^ 32'h5A5A_C3C3;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic expect_hash(input logic [11:0] s, input logic [35:0] a, input logic [31:0] c);
    msgq.push_back({s, a, c});
    seedq.push_back({1'b0, hfn({s, a, c})});
  endtask

  task automatic send_snd(input logic [11:0] d);
    @(posedge clk); #1;
    snd_valid_i = 1'b1; snd_data_i = d;
    do @(negedge clk); while (!snd_ready_o);
    @(posedge clk); #1;
    snd_valid_i = 1'b0;
  endtask

  task automatic send_acc(input logic [35:0] d);
    @(posedge clk); #1;
    acc_valid_i = 1'b1; acc_data_i = d;
    do @(negedge clk); while (!acc_ready_o);
    @(posedge clk); #1;
    acc_valid_i = 1'b0;
  endtask

  task automatic wait_seed(input int k);
    while (seeds_seen < k) @(negedge clk);
  endtask

  task automatic wait_collect();
    do @(negedge clk); while (!(snd_ready_o || acc_ready_o));
  endtask

  task automatic check_blocks(input int n);
    int e;
    e = (n == 0) ? 1 : n;
    chk(blk_since == e, "R8 words per seed", 64'(blk_since), 64'(e));
    chk(!blk_ready_o, "R8 cipher ready low while collecting", 64'(blk_ready_o), 64'd0);
    chk(stq.size() == 0, "R9 recorded words all stored", 64'(stq.size()), 64'd0);
    blk_since = 0;
  endtask

  // ready patterns for hash, seed and sink
  initial begin
    hreq_ready_i = 1'b0; seed_ready_i = 1'b0; sto_ready_i = 1'b0;
    forever begin
      @(posedge clk); #1;
      cyc = cyc + 1;
      hreq_ready_i = cyc[0];
      seed_ready_i = (cyc[1:0] != 2'b00);
      sto_ready_i  = (cyc[1:0] != 2'b11);
    end
  end

  // cipher model: new word after each transfer
  initial begin
    blk_valid_i = 1'b1;
    blk_data_i  = 32'h1000_0001;
    forever begin
      @(posedge clk); #1;
      if (blk_step) begin
        blk_data_i = blk_data_i + 32'h0101_0103;
        blk_step = 0;
      end
    end
  end

  // hash engine model and request scoreboard
  initial begin
    logic [79:0] m;
    hrsp_valid_i = 1'b0;
    hrsp_data_i  = '0;
    forever begin
      @(negedge clk);
      if (hreq_valid_o && hreq_ready_i) begin
        if (msgq.size() == 0) begin
          chk(1'b0, "R6 hash request without expected mix", 64'(hreq_data_o[63:0]), 64'd0);
          m = hreq_data_o;
        end else begin
          m = msgq.pop_front();
          chk(hreq_data_o == m, "R4 hash payload", hreq_data_o[63:0], m[63:0]);
        end
        repeat (2) @(posedge clk);
        #1;
        hrsp_valid_i = 1'b1;
        hrsp_data_i  = hfn(m);
        do @(negedge clk); while (!hrsp_ready_o);
        @(posedge clk); #1;
        hrsp_valid_i = 1'b0;
      end
    end
  end

  // output monitor: seeds, cipher words, sink words
  initial begin
    logic [32:0] e;
    logic [31:0] w;
    forever begin
      @(negedge clk);
      if (rst_n && seed_valid_o && seed_ready_i) begin
        seeds_seen++;
        if (seedq.size() == 0) begin
          chk(1'b0, "R5 unexpected seed", 64'({seed_fb_o, seed_data_o}), 64'd0);
        end else begin
          e = seedq.pop_front();
          chk({seed_fb_o, seed_data_o} == e, e[32] ? "R6 fallback seed" : "R5 mixed seed",
              64'({seed_fb_o, seed_data_o}), 64'(e));
        end
      end
      if (rst_n && blk_valid_i && blk_ready_o) begin
        blk_since++;
        blk_step = 1;
        if (rec_en_i) stq.push_back(blk_data_i);
      end
      if (rst_n && sto_valid_o && !rec_en_i)
        chk(1'b0, "R9 sink valid with recording off", 64'd1, 64'd0);
      if (rst_n && sto_valid_o && sto_ready_i) begin
        sto_cnt++;
        if (stq.size() == 0) begin
          chk(1'b0, "R9 unexpected sink word", 64'(sto_data_o), 64'd0);
        end else begin
          w = stq.pop_front();
          chk(sto_data_o == w, "R9 sink word", 64'(sto_data_o), 64'(w));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog: act=hung exp=finished");
    finish_run();
  end

  initial begin
    bit ok;
    int sto_mark;
    rst_n = 1'b0; soft_rst_i = 1'b0; start_i = 1'b0; rec_en_i = 1'b1;
    tmo_cfg_i = 16'd200; blk_cfg_i = 8'd3; chaos_i = 32'h1357_9BDF;
    snd_valid_i = 1'b0; snd_data_i = '0; acc_valid_i = 1'b0; acc_data_i = '0;

    repeat (3) @(negedge clk);
    chk(!snd_ready_o && !acc_ready_o && !hreq_valid_o && !hrsp_ready_o && !seed_valid_o
        && !blk_ready_o && !sto_valid_o && !timeout_o, "R1 outputs in reset",
        64'({snd_ready_o, acc_ready_o, hreq_valid_o, hrsp_ready_o, seed_valid_o,
             blk_ready_o, sto_valid_o, timeout_o}), 64'd0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R2: no start, sensors offering data
    snd_valid_i = 1'b1; acc_valid_i = 1'b1;
    ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (snd_ready_o || acc_ready_o || hreq_valid_o || seed_valid_o) ok = 1'b0;
    end
    chk(ok, "R2 idle without start", 64'(!ok), 64'd0);
    @(posedge clk); #1 snd_valid_i = 1'b0; acc_valid_i = 1'b0;

    // segment 1: mixed seed, recording on, three words
    start_i = 1'b1;
    expect_hash(12'hA51, 36'h1_2345_6789, chaos_i);
    send_snd(12'hA51);
    ok = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (snd_ready_o || hreq_valid_o || !acc_ready_o) ok = 1'b0;
    end
    chk(ok, "R3 sound held, waiting for accel", 64'(!ok), 64'd0);
    send_acc(36'h1_2345_6789);
    wait_seed(1);
    wait_collect();
    chk(snd_ready_o && acc_ready_o, "R7 both ports reopened after mix",
        64'({snd_ready_o, acc_ready_o}), 64'h3);
    check_blocks(3);
    chk(!timeout_o, "R6 no flag without timeout", 64'(timeout_o), 64'd0);

    // segment 2: recording off, two words
    rec_en_i = 1'b0; blk_cfg_i = 8'd2; chaos_i = 32'hCAFE_0042;
    sto_mark = sto_cnt;
    expect_hash(12'h3C7, 36'hF_0F0F_1234, chaos_i);
    fork
      send_snd(12'h3C7);
      send_acc(36'hF_0F0F_1234);
    join
    wait_seed(2);
    wait_collect();
    check_blocks(2);
    chk(sto_cnt == sto_mark, "R9 nothing stored with recording off",
        64'(sto_cnt - sto_mark), 64'd0);

    // segment 3: timeout with only sound delivered
    rec_en_i = 1'b1; blk_cfg_i = 8'd1; tmo_cfg_i = 16'd20; chaos_i = 32'h0BAD_F00D;
    seedq.push_back({1'b1, 32'h0BAD_F00D});
    send_snd(12'h7E2);
    wait_seed(3);
    tmo_cfg_i = 16'd200; chaos_i = 32'h7777_1111;
    chk(timeout_o, "R6 flag set on fallback", 64'(timeout_o), 64'd1);
    wait_collect();
    chk(acc_ready_o && !snd_ready_o, "R7 held sound kept across timeout",
        64'({snd_ready_o, acc_ready_o}), 64'h1);
    check_blocks(1);

    // segment 4: held sound plus new accel, word count 0 acts as 1
    blk_cfg_i = 8'd0;
    expect_hash(12'h7E2, 36'h8_8888_0001, 32'h7777_1111);
    send_acc(36'h8_8888_0001);
    wait_seed(4);
    chk(timeout_o, "R6 flag sticky", 64'(timeout_o), 64'd1);
    wait_collect();
    check_blocks(0);

    // segment 5: soft reset discards a partial sample
    send_snd(12'h111);
    start_i = 1'b0;
    @(posedge clk); #1 soft_rst_i = 1'b1;
    @(posedge clk); #1 soft_rst_i = 1'b0;
    @(negedge clk);
    chk(!snd_ready_o && !acc_ready_o && !hreq_valid_o && !seed_valid_o && !blk_ready_o
        && !timeout_o, "R1 outputs after soft reset",
        64'({snd_ready_o, acc_ready_o, hreq_valid_o, seed_valid_o, blk_ready_o, timeout_o}),
        64'd0);
    ok = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (snd_ready_o || acc_ready_o) ok = 1'b0;
    end
    chk(ok, "R2 idle after soft reset until start", 64'(!ok), 64'd0);
    start_i = 1'b1; chaos_i = 32'h2468_ACE0;
    wait_collect();
    chk(snd_ready_o && acc_ready_o, "R10 partial sample cleared",
        64'({snd_ready_o, acc_ready_o}), 64'h3);
    expect_hash(12'h5D5, 36'h0_ABCD_EF01, 32'h2468_ACE0);
    fork
      send_snd(12'h5D5);
      send_acc(36'h0_ABCD_EF01);
    join
    wait_seed(5);
    wait_collect();
    check_blocks(0);
    chk(msgq.size() == 0 && seedq.size() == 0, "R5 all expected seeds seen",
        64'(msgq.size() + seedq.size()), 64'd0);
    finish_run();
  end
endmodule